// File: doc/BRIEF.md
# Saturating P/V Semaphore Cell

This block is a single counting-semaphore storage cell for a hardware inter-thread synchronisation unit. An upstream address decoder presents one access per cycle, tagged with a view code, a read/write flag and the id of the requesting hardware thread. Reads through the two P views take a unit from the count. One view waits when the count is empty and the other does not. Writes through either P view give a unit back. A raw view reads the count without side effects.

A P request through the waiting view that finds the count at zero is refused with a stall response. The thread's bit is then kept in a waiter mask. The next give-back raises a one-cycle wake pulse for every parked thread and empties the mask, and each woken thread then issues its request again. All responses are registered and appear in the cycle after the request. The thread scheduler that acts on stall and wake lies outside the block.

Top module: `sem_pv_cell`

## Requirements
- R1: A read through view code 4 or 5 returns, one cycle later on `rsp_data`, the count as it stood before the request. When that count is above zero it is lowered by one.
- R2: A read through view code 4 that finds the count at zero raises `rsp_stall` one cycle later, parks the requesting thread in the waiter mask, and leaves the count at zero.
- R3: A read through view code 5 that finds the count at zero returns 0, never raises `rsp_stall`, and parks no thread.
- R4: A write through view code 4 or 5 raises the count by one whatever `req_wdata` holds.
- R5: The count saturates at 2**COUNT_W-1 (0xFFFF by default). A give-back at that value leaves it there.
- R6: A give-back made while threads are parked drives `wake`, for exactly one cycle in the cycle after the request, with one bit set per parked thread (bit n for thread id n). The waiter mask is then empty, so a further give-back wakes nobody.
- R7: A read through view code 0 returns the count and leaves it unchanged. A write through view code 0 has no effect.
- R8: After reset the count is zero, no thread is parked, and `rsp_data`, `rsp_stall` and `wake` are zero.
- R9: A request with any view code other than 0, 4 or 5 changes nothing and returns 0. `rsp_data` is 0 in every cycle that does not follow a read through view 0, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_view | input | VIEW_W | View code from the decoder |
| req_thread | input | TID_W | Id of the requesting thread |
| req_wdata | input | DATA_W | Write data (not used by this cell) |
| rsp_data | output | DATA_W | Read result, one cycle after the request |
| rsp_stall | output | 1 | Request refused, thread parked |
| wake | output | NUM_THREADS | One-cycle wake pulse per parked thread |

## Verification
The bench builds the cell with COUNT_W=4, DATA_W=32 and eight threads. The saturation ceiling is then 15, so seventeen give-backs push the count against it within a few cycles. That makes the ceiling behaviour reachable without sixty-five thousand operations. Eight threads let two non-adjacent waiters park together, which tests that the wake vector carries exactly their bits.

// File: rtl/sem_pv_pkg.sv
package sem_pv_pkg;

   localparam int VIEW_W = 4;

   localparam logic [VIEW_W-1:0] VIEW_RAW    = 4'd0;
   localparam logic [VIEW_W-1:0] VIEW_P_WAIT = 4'd4;
   localparam logic [VIEW_W-1:0] VIEW_P_TRY  = 4'd5;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_RAW_RD = 3'd1,
      OP_P_WAIT = 3'd2,
      OP_P_TRY  = 3'd3,
      OP_GIVE   = 3'd4
   } sem_op_t;

endpackage

// File: rtl/sem_view_decode.sv
module sem_view_decode
   import sem_pv_pkg::*;
(
   input  logic              valid,
   input  logic              write,
   input  logic [VIEW_W-1:0] view,
   output sem_op_t           op
);
   always_comb begin
      op = OP_NONE;
      if (valid) begin
         unique case (view)
            VIEW_RAW:               op = write ? OP_NONE : OP_RAW_RD;
            VIEW_P_WAIT:            op = write ? OP_GIVE : OP_P_WAIT;
            VIEW_P_TRY:             op = write ? OP_GIVE : OP_P_TRY;
            default:                op = OP_NONE;
         endcase
      end
   end
endmodule

// File: rtl/sem_sat_counter.sv
module sem_sat_counter #(
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic               dec,
   output logic [COUNT_W-1:0] count,
   output logic               at_zero
);
   localparam logic [COUNT_W-1:0] MAX_COUNT = {COUNT_W{1'b1}};

   initial begin
      if (COUNT_W < 1 || COUNT_W > 32)
         $error("sem_sat_counter: COUNT_W must be 1..32");
   end

   assign at_zero = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc && count != MAX_COUNT) begin
         count <= count + 1'b1;
      end else if (dec && !at_zero) begin
         count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/sem_waiter_mask.sv
module sem_waiter_mask #(
   parameter int NUM_THREADS = 8,
   parameter int TID_W       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   park,
   input  logic [TID_W-1:0]       park_tid,
   input  logic                   release_all,
   output logic [NUM_THREADS-1:0] waiters,
   output logic [NUM_THREADS-1:0] wake
);
   initial begin
      if (NUM_THREADS < 1) $error("sem_waiter_mask: NUM_THREADS must be >= 1");
      if ((1 << TID_W) < NUM_THREADS) $error("sem_waiter_mask: TID_W too narrow");
   end

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
      logic hit;
      assign hit = park && (park_tid == TID_W'(t));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            waiters[t] <= 1'b0;
            wake[t]    <= 1'b0;
         end else begin
            wake[t] <= release_all && waiters[t];
            if (release_all)
               waiters[t] <= 1'b0;
            else if (hit)
               waiters[t] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sem_pv_cell.sv
module sem_pv_cell
   import sem_pv_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int COUNT_W     = 16,
   parameter int NUM_THREADS = 8,
   parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [VIEW_W-1:0]      req_view,
   input  logic [TID_W-1:0]       req_thread,
   input  logic [DATA_W-1:0]      req_wdata,
   output logic [DATA_W-1:0]      rsp_data,
   output logic                   rsp_stall,
   output logic [NUM_THREADS-1:0] wake
);
   initial begin
      if (COUNT_W > DATA_W) $error("sem_pv_cell: COUNT_W exceeds DATA_W");
   end

   sem_op_t                op;
   logic [COUNT_W-1:0]     count;
   logic                   at_zero;
   logic                   is_take;
   logic                   park;
   logic                   give;
   logic [NUM_THREADS-1:0] waiters;
   logic [DATA_W-1:0]      count_ext;
   logic                   unused_wdata;

   assign unused_wdata = ^req_wdata;

   sem_view_decode u_dec (
      .valid (req_valid),
      .write (req_write),
      .view  (req_view),
      .op    (op)
   );

   assign is_take = (op == OP_P_WAIT) || (op == OP_P_TRY);
   assign give    = (op == OP_GIVE);
   assign park    = (op == OP_P_WAIT) && at_zero;

   sem_sat_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (give),
      .dec     (is_take),
      .count   (count),
      .at_zero (at_zero)
   );

   sem_waiter_mask #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .park        (park),
      .park_tid    (req_thread),
      .release_all (give),
      .waiters     (waiters),
      .wake        (wake)
   );

   if (COUNT_W < DATA_W) begin : g_pad
      assign count_ext = {{(DATA_W-COUNT_W){1'b0}}, count};
   end else begin : g_full
      assign count_ext = count;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_data  <= '0;
         rsp_stall <= 1'b0;
      end else begin
         rsp_data  <= (is_take || op == OP_RAW_RD) ? count_ext : '0;
         rsp_stall <= park;
      end
   end
endmodule

// File: rtl/sem_pv_cell_chk.sv
module sem_pv_cell_chk
   import sem_pv_pkg::*;
#(
   parameter int COUNT_W     = 16,
   parameter int NUM_THREADS = 8,
   parameter int TID_W       = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_write,
   input logic [VIEW_W-1:0]      req_view,
   input logic [TID_W-1:0]       req_thread,
   input logic [COUNT_W-1:0]     count,
   input logic [NUM_THREADS-1:0] waiters,
   input logic [NUM_THREADS-1:0] wake,
   input logic                   rsp_stall
);
   localparam logic [COUNT_W-1:0] MAX_COUNT = {COUNT_W{1'b1}};

   logic p_rd, v_wr, raw;
   assign p_rd = req_valid && !req_write && (req_view == VIEW_P_WAIT || req_view == VIEW_P_TRY);
   assign v_wr = req_valid && req_write && (req_view == VIEW_P_WAIT || req_view == VIEW_P_TRY);
   assign raw  = req_valid && req_view == VIEW_RAW;

   // R1
   take_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rd && count != '0) |=> count == $past(count) - 1'b1);

   // R2
   park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_view == VIEW_P_WAIT && count == '0)
      |=> rsp_stall && waiters[$past(req_thread)] && count == '0);

   // R3
   try_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_view == VIEW_P_TRY) |=> !rsp_stall);

   // R5
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_wr && count == MAX_COUNT) |=> count == MAX_COUNT);

   // R6
   wake_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_wr |=> (wake == $past(waiters)) && (waiters == '0));

   // R6
   wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake != '0) |-> $past(v_wr));

   // R7
   raw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raw |=> $stable(count) && $stable(waiters));
endmodule

bind sem_pv_cell sem_pv_cell_chk #(
   .COUNT_W(COUNT_W), .NUM_THREADS(NUM_THREADS), .TID_W(TID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_view(req_view), .req_thread(req_thread), .count(count),
   .waiters(waiters), .wake(wake), .rsp_stall(rsp_stall)
);

// File: tb/tb_sem_pv_cell.sv
module tb_sem_pv_cell;
   localparam int DATA_W = 32;
   localparam int COUNT_W = 4;
   localparam int NT = 8;
   localparam int TW = 3;
   localparam int MAXV = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [3:0] req_view = '0;
   logic [TW-1:0] req_thread = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [DATA_W-1:0] rsp_data;
   logic rsp_stall;
   logic [NT-1:0] wake;

   int tests = 0, fails = 0;
   logic [DATA_W-1:0] got_d;
   logic got_s;
   logic [NT-1:0] got_w;

   always #5 clk = ~clk;

   sem_pv_cell #(.DATA_W(DATA_W), .COUNT_W(COUNT_W), .NUM_THREADS(NT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_view(req_view), .req_thread(req_thread), .req_wdata(req_wdata),
      .rsp_data(rsp_data), .rsp_stall(rsp_stall), .wake(wake));

   task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // starts and ends at a negedge; captures the response of this request
   task automatic op(input logic wr, input logic [3:0] v, input int tid,
                     input logic [DATA_W-1:0] wd);
      req_valid = 1'b1; req_write = wr; req_view = v;
      req_thread = TW'(tid); req_wdata = wd;
      @(negedge clk);
      got_d = rsp_data; got_s = rsp_stall; got_w = wake;
      req_valid = 1'b0; req_write = 1'b0; req_view = '0;
   endtask

   task automatic peek(string tag, int exp);
      op(1'b0, 4'd0, 0, '0);
      check(tag, got_d, DATA_W'(exp));
   endtask

   task automatic t_reset;
      check("R8 data", rsp_data, '0);
      check("R8 stall", {31'd0, rsp_stall}, '0);
      check("R8 wake", {24'd0, wake}, '0);
      peek("R8 count", 0);
   endtask

   task automatic t_try_zero;
      op(1'b0, 4'd5, 1, '0);
      check("R3 data", got_d, '0);
      check("R3 stall", {31'd0, got_s}, '0);
      op(1'b1, 4'd4, 0, '0);
      check("R3 no park wake", {24'd0, got_w}, '0);
      op(1'b0, 4'd5, 0, '0);
   endtask

   task automatic t_take_give;
      op(1'b1, 4'd4, 0, 32'hDEAD_BEEF);
      op(1'b1, 4'd5, 3, 32'h0);
      op(1'b1, 4'd4, 7, 32'hFFFF_FFFF);
      peek("R4 three gives", 3);
      op(1'b0, 4'd5, 2, '0);
      check("R1 try returns old", got_d, 32'd3);
      peek("R1 try decrements", 2);
      op(1'b0, 4'd4, 2, '0);
      check("R1 wait returns old", got_d, 32'd2);
      check("R1 wait no stall", {31'd0, got_s}, '0);
      peek("R1 wait decrements", 1);
      op(1'b0, 4'd9, 0, '0);
      check("R9 bad view read", got_d, '0);
      op(1'b1, 4'd1, 0, 32'hFFFF);
      op(1'b1, 4'd2, 0, 32'hFFFF);
      op(1'b0, 4'd3, 0, '0);
      check("R9 idle data", got_d, '0);
      peek("R9 count kept", 1);
   endtask

   task automatic t_raw;
      op(1'b1, 4'd0, 0, 32'h7);
      peek("R7 raw write ignored", 1);
      peek("R7 raw read repeat", 1);
      op(1'b0, 4'd5, 0, '0);
      peek("R7 drained", 0);
   endtask

   task automatic t_block;
      op(1'b0, 4'd4, 2, '0);
      check("R2 stall t2", {31'd0, got_s}, 32'd1);
      check("R2 data", got_d, '0);
      op(1'b0, 4'd4, 5, '0);
      check("R2 stall t5", {31'd0, got_s}, 32'd1);
      peek("R2 count unchanged", 0);
      op(1'b1, 4'd5, 0, '0);
      check("R6 wake vector", {24'd0, got_w}, 32'h24);
      op(1'b0, 4'd0, 0, '0);
      check("R6 pulse one cycle", {24'd0, got_w}, '0);
      op(1'b1, 4'd4, 0, '0);
      check("R6 mask cleared", {24'd0, got_w}, '0);
      peek("R6 count", 2);
      op(1'b0, 4'd5, 0, '0);
      op(1'b0, 4'd5, 0, '0);
   endtask

   task automatic t_sat;
      for (int i = 0; i < 17; i++) op(1'b1, 4'd4, 0, '0);
      peek("R5 ceiling", MAXV);
      op(1'b0, 4'd5, 0, '0);
      check("R5 take at ceiling", got_d, 32'(MAXV));
      peek("R5 after take", MAXV - 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_try_zero();
      t_take_give();
      t_raw();
      t_block();
      t_sat();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule